// File: doc/BRIEF.md
# Five-Step Subranging Conversion Sequencer

This block sequences one complete subranging analog-to-digital conversion and the autozero that follows it. A conversion runs five steps. Each step opens with a decision phase and closes with a subtraction phase. During the decision phase an external step controller closes reference segments one at a time and returns a 5-bit code. The sequencer itself only sets up the analog switches and hands the decision over through a start/done handshake. During the subtraction phase the remainder amplifier is given a feedback path with a gain of sixteen through one of two storage channels. The stored remainder then becomes the input of the next step. The channels take turns, so each step reads the remainder written by the step before it.

The sign of the first step is taken from the comparator just after the input is applied. Because the remainder amplifier inverts, the reference polarity reverses on every later step. Each code is added or subtracted according to its step's polarity, and the running sum is scaled by sixteen before each new code. The result is one signed word. Once the sample is complete, the amplifier is zeroed through the X channel. The reference is then zeroed in two phases. Analog settling is represented only by parameterised wait counts.

Top module: `csq_sequencer`

## Requirements
- R1: After reset, and whenever no conversion is running, every switch output is open (0), and `busy_o`, `done_o` and `dec_start_o` are 0.
- R2: A `start_i` pulse while idle begins a conversion. After one all-open cycle, a single sense cycle closes the input switch and G. `cmp_i` is sampled in that cycle.
- R3: Each of the five steps asserts `dec_start_o` for exactly one cycle, on the first cycle of its decision phase. The block then holds the decision phase until `dec_done_i` is 1, and takes `dec_code_i` in that cycle.
- R4: The subtraction phase lasts SUB_WAIT cycles. G is open, and the storing channel has its feedback and storage switches closed. Steps 0, 2 and 4 store on X; steps 1 and 3 store on Y.
- R5: In the decision phase G is closed. Step 0 closes the input switch. A later step instead closes the readback switch of the channel written by the previous step. That channel's feedback and storage switches stay open, and the readback stays closed through the step's subtraction phase.
- R6: The step sign is `cmp_i` (sampled in the sense cycle) XOR the parity of the step index. Sign 1 closes `ref_a1_o` and opens `ref_a2_o`; sign 0 does the reverse. The two are never closed together.
- R7: Before G closes, and before any change of the input or channel switches, one cycle passes with all of them and G open. The X and Y feedback switches are never closed together.
- R8: After the last subtraction, the amplifier autozero (`az_amp_o` together with `sw_x_fb_o`) is held for AZ_WAIT cycles, with the reference switches open.
- R9: The reference is then autozeroed in two phases of AZ_WAIT cycles each. First A1 is closed and A2 open. Then A1 and A2 are both open and `az_ref_o` is closed.
- R10: `done_o` is high for exactly one cycle. `result_o` then equals the sum over steps k=0..4 of (+code_k if its sign is 1, else -code_k) times 16^(4-k), and it holds that value until the next conversion starts.
- R11: A `start_i` that arrives while `busy_o` is 1 has no effect: the running conversion and its result are unchanged, and no second conversion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a conversion when idle |
| cmp_i | input | 1 | Comparator output, 1 = summing node positive |
| dec_done_i | input | 1 | Step controller finished the decision phase |
| dec_code_i | input | CODE_W | Code found in the decision phase |
| dec_start_o | output | 1 | One-cycle request to start a decision phase |
| busy_o | output | 1 | Conversion or autozero in progress |
| done_o | output | 1 | One-cycle result strobe |
| result_o | output | CODE_W+4*(STEPS-1)+2 | Signed conversion result |
| sw_in_o | output | 1 | Input switch |
| sw_g_o | output | 1 | Comparator gate switch G |
| sw_x_fb_o | output | 1 | X channel feedback switch |
| sw_x_st_o | output | 1 | X channel storage switch |
| sw_x_rd_o | output | 1 | X channel readback switch |
| sw_y_fb_o | output | 1 | Y channel feedback switch |
| sw_y_st_o | output | 1 | Y channel storage switch |
| sw_y_rd_o | output | 1 | Y channel readback switch |
| ref_a1_o | output | 1 | Reference amplifier non-inverting select (A1) |
| ref_a2_o | output | 1 | Reference amplifier inverting select (A2) |
| az_amp_o | output | 1 | Remainder amplifier autozero |
| az_ref_o | output | 1 | Reference autozero switches (Z1, Z2) |

## Verification
The hardest situation to reach from the ports is a start request that lands in the middle of a conversion, deep inside a later step's decision phase, combined with decision phases of varying length. The bench follows the sequence cycle by cycle and answers each decision request after a random delay of zero to three cycles. In one conversion it pulses `start_i` during step 2. It then checks that the result matches the signed weighted sum and that no second conversion begins. Directed runs with all-ones and all-zero codes under both first-step signs cover the extremes of the sum.

// File: rtl/csq_pkg.sv
package csq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GAP,
        ST_SENSE,
        ST_DECIDE,
        ST_SUB,
        ST_AZ_AMP,
        ST_AZ_REF1,
        ST_AZ_REF2,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic in_sw;
        logic g_sw;
        logic x_fb;
        logic x_st;
        logic x_rd;
        logic y_fb;
        logic y_st;
        logic y_rd;
        logic ref_a1;
        logic ref_a2;
        logic az_amp;
        logic az_ref;
    } sw_bank_t;

    // Sign of a step: first-step sign flipped on every odd step (inverting amplifier).
    function automatic logic step_sign(input logic first_sign, input logic step_odd);
        return first_sign ^ step_odd;
    endfunction

    // Steps with an odd index store on Y, even ones on X.
    function automatic logic stores_on_y(input logic step_odd);
        return step_odd;
    endfunction

endpackage

// File: rtl/csq_wait_timer.sv
module csq_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/csq_accum.sv
module csq_accum #(
    parameter int CODE_W = 5,
    parameter int SHIFT  = 4,
    parameter int RES_W  = 23
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    en,
    input  logic                    add,
    input  logic [CODE_W-1:0]       code,
    output logic signed [RES_W-1:0] acc
);
    logic signed [RES_W-1:0] code_ext;
    logic signed [RES_W-1:0] term;

    always_comb begin
        code_ext = signed'({{(RES_W-CODE_W){1'b0}}, code});
        term     = add ? code_ext : -code_ext;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= (acc <<< SHIFT) + term;
        end
    end
endmodule

// File: rtl/csq_switch_map.sv
module csq_switch_map
    import csq_pkg::*;
(
    input  seq_state_e state,
    input  seq_state_e gap_tgt,
    input  logic       first_step,
    input  logic       step_odd,
    input  logic       sign,
    output sw_bank_t   sw
);
    logic on_y;

    always_comb begin
        on_y = stores_on_y(step_odd);
        sw   = '0;
        unique case (state)
            ST_SENSE: begin
                sw.in_sw = 1'b1;
                sw.g_sw  = 1'b1;
            end
            ST_DECIDE, ST_SUB: begin
                sw.g_sw   = (state == ST_DECIDE);
                sw.ref_a1 = sign;
                sw.ref_a2 = !sign;
                if (first_step) begin
                    sw.in_sw = 1'b1;
                end else if (on_y) begin
                    sw.x_rd = 1'b1;
                end else begin
                    sw.y_rd = 1'b1;
                end
                if (state == ST_SUB) begin
                    if (on_y) begin
                        sw.y_fb = 1'b1;
                        sw.y_st = 1'b1;
                    end else begin
                        sw.x_fb = 1'b1;
                        sw.x_st = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (gap_tgt == ST_DECIDE || gap_tgt == ST_SUB) begin
                    sw.ref_a1 = sign;
                    sw.ref_a2 = !sign;
                end
            end
            ST_AZ_AMP: begin
                sw.az_amp = 1'b1;
                sw.x_fb   = 1'b1;
            end
            ST_AZ_REF1: sw.ref_a1 = 1'b1;
            ST_AZ_REF2: sw.az_ref = 1'b1;
            default: sw = '0;
        endcase
    end
endmodule

// File: rtl/csq_sequencer.sv
module csq_sequencer
    import csq_pkg::*;
#(
    parameter int CODE_W   = 5,
    parameter int STEPS    = 5,
    parameter int SUB_WAIT = 4,
    parameter int AZ_WAIT  = 3
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic                                       start_i,
    input  logic                                       cmp_i,
    input  logic                                       dec_done_i,
    input  logic [CODE_W-1:0]                          dec_code_i,
    output logic                                       dec_start_o,
    output logic                                       busy_o,
    output logic                                       done_o,
    output logic signed [CODE_W+4*(STEPS-1)+1:0]       result_o,
    output logic                                       sw_in_o,
    output logic                                       sw_g_o,
    output logic                                       sw_x_fb_o,
    output logic                                       sw_x_st_o,
    output logic                                       sw_x_rd_o,
    output logic                                       sw_y_fb_o,
    output logic                                       sw_y_st_o,
    output logic                                       sw_y_rd_o,
    output logic                                       ref_a1_o,
    output logic                                       ref_a2_o,
    output logic                                       az_amp_o,
    output logic                                       az_ref_o
);
    localparam int GAIN_SHIFT = 4;
    localparam int RES_W      = CODE_W + GAIN_SHIFT*(STEPS-1) + 2;
    localparam int STEP_W     = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam int MAX_WAIT   = (SUB_WAIT > AZ_WAIT) ? SUB_WAIT : AZ_WAIT;
    localparam int CNT_W      = $clog2(MAX_WAIT + 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);
    localparam logic [CNT_W-1:0]  SUB_LD    = CNT_W'(SUB_WAIT - 1);
    localparam logic [CNT_W-1:0]  AZ_LD     = CNT_W'(AZ_WAIT - 1);

    seq_state_e        state_q, state_d;
    seq_state_e        tgt_q, tgt_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic              sgn0_q, sgn0_d;
    logic              dstart_q, dstart_d;
    logic              t_load, t_expired;
    logic [CNT_W-1:0]  t_val;
    logic              acc_clr, acc_en;
    logic              sgn_cur;
    sw_bank_t          sw;

    assign sgn_cur = step_sign(sgn0_q, step_q[0]);

    always_comb begin
        state_d  = state_q;
        tgt_d    = tgt_q;
        step_d   = step_q;
        sgn0_d   = sgn0_q;
        dstart_d = 1'b0;
        t_load   = 1'b0;
        t_val    = '0;
        acc_clr  = 1'b0;
        acc_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_GAP;
                    tgt_d   = ST_SENSE;
                    step_d  = '0;
                    acc_clr = 1'b1;
                end
            end
            ST_GAP: begin
                state_d = tgt_q;
                if (tgt_q == ST_SUB) begin
                    t_load = 1'b1;
                    t_val  = SUB_LD;
                end else if (tgt_q == ST_AZ_AMP || tgt_q == ST_AZ_REF1) begin
                    t_load = 1'b1;
                    t_val  = AZ_LD;
                end else if (tgt_q == ST_DECIDE) begin
                    dstart_d = 1'b1;
                end
            end
            ST_SENSE: begin
                sgn0_d   = cmp_i;
                state_d  = ST_DECIDE;
                dstart_d = 1'b1;
            end
            ST_DECIDE: begin
                if (dec_done_i) begin
                    acc_en  = 1'b1;
                    tgt_d   = ST_SUB;
                    state_d = ST_GAP;
                end
            end
            ST_SUB: begin
                if (t_expired) begin
                    state_d = ST_GAP;
                    if (step_q == LAST_STEP) begin
                        tgt_d = ST_AZ_AMP;
                    end else begin
                        step_d = step_q + 1'b1;
                        tgt_d  = ST_DECIDE;
                    end
                end
            end
            ST_AZ_AMP: begin
                if (t_expired) begin
                    state_d = ST_GAP;
                    tgt_d   = ST_AZ_REF1;
                end
            end
            ST_AZ_REF1: begin
                if (t_expired) begin
                    state_d = ST_AZ_REF2;
                    t_load  = 1'b1;
                    t_val   = AZ_LD;
                end
            end
            ST_AZ_REF2: begin
                if (t_expired) state_d = ST_FIN;
            end
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            tgt_q    <= ST_SENSE;
            step_q   <= '0;
            sgn0_q   <= 1'b0;
            dstart_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            tgt_q    <= tgt_d;
            step_q   <= step_d;
            sgn0_q   <= sgn0_d;
            dstart_q <= dstart_d;
        end
    end

    csq_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    csq_accum #(.CODE_W(CODE_W), .SHIFT(GAIN_SHIFT), .RES_W(RES_W)) u_accum (
        .clk  (clk),
        .rst  (rst),
        .clr  (acc_clr),
        .en   (acc_en),
        .add  (sgn_cur),
        .code (dec_code_i),
        .acc  (result_o)
    );

    csq_switch_map u_map (
        .state      (state_q),
        .gap_tgt    (tgt_q),
        .first_step (step_q == '0),
        .step_odd   (step_q[0]),
        .sign       (sgn_cur),
        .sw         (sw)
    );

    assign dec_start_o = dstart_q;
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = (state_q == ST_FIN);
    assign sw_in_o     = sw.in_sw;
    assign sw_g_o      = sw.g_sw;
    assign sw_x_fb_o   = sw.x_fb;
    assign sw_x_st_o   = sw.x_st;
    assign sw_x_rd_o   = sw.x_rd;
    assign sw_y_fb_o   = sw.y_fb;
    assign sw_y_st_o   = sw.y_st;
    assign sw_y_rd_o   = sw.y_rd;
    assign ref_a1_o    = sw.ref_a1;
    assign ref_a2_o    = sw.ref_a2;
    assign az_amp_o    = sw.az_amp;
    assign az_ref_o    = sw.az_ref;
endmodule

// File: rtl/csq_seq_checker.sv
module csq_seq_checker (
    input logic clk,
    input logic rst,
    input logic dec_start_o,
    input logic busy_o,
    input logic done_o,
    input logic sw_in_o,
    input logic sw_g_o,
    input logic sw_x_fb_o,
    input logic sw_x_st_o,
    input logic sw_x_rd_o,
    input logic sw_y_fb_o,
    input logic sw_y_st_o,
    input logic sw_y_rd_o,
    input logic ref_a1_o,
    input logic ref_a2_o,
    input logic az_amp_o,
    input logic az_ref_o
);
    logic [6:0] chan;
    assign chan = {sw_in_o, sw_x_fb_o, sw_x_st_o, sw_x_rd_o, sw_y_fb_o, sw_y_st_o, sw_y_rd_o};

    // R1: idle means every switch open
    p_idle_open_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (chan == '0 && !sw_g_o && !ref_a1_o && !ref_a2_o && !az_amp_o && !az_ref_o));

    // R3: decision request only while busy, never two cycles in a row
    p_dec_start_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        dec_start_o |-> busy_o ##1 !dec_start_o);

    // R4: G is open whenever a channel stores
    p_g_open_in_sub_r4: assert property (@(posedge clk) disable iff (rst)
        sw_g_o |-> !(sw_x_fb_o || sw_y_fb_o || sw_x_st_o || sw_y_st_o));

    // R6: both reference selects never closed together
    p_ref_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(ref_a1_o && ref_a2_o));

    // R7: never two feedback paths
    p_one_feedback_r7: assert property (@(posedge clk) disable iff (rst)
        !(sw_x_fb_o && sw_y_fb_o));

    // R7: any change of a closed channel pattern passes through all-open
    p_break_before_change_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(chan) != '0 && chan != $past(chan)) |-> chan == '0);

    // R7: G closes only after an all-open cycle
    p_break_before_g_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(sw_g_o) |-> ($past(chan) == '0));

    // R10: result strobe lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

bind csq_sequencer csq_seq_checker u_chk (.*);

// File: tb/tb_csq_sequencer.sv
module tb_csq_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int CODE_W     = 5;
    localparam int STEPS      = 5;
    localparam int SUB_W      = 3;
    localparam int AZ_W       = 2;
    localparam int RES_W      = CODE_W + 4*(STEPS-1) + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, cmp_i = 1'b0, dec_done_i = 1'b0;
    logic [CODE_W-1:0] dec_code_i = '0;
    logic dec_start_o, busy_o, done_o;
    logic signed [RES_W-1:0] result_o;
    logic sw_in_o, sw_g_o, sw_x_fb_o, sw_x_st_o, sw_x_rd_o, sw_y_fb_o, sw_y_st_o, sw_y_rd_o;
    logic ref_a1_o, ref_a2_o, az_amp_o, az_ref_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csq_sequencer #(.CODE_W(CODE_W), .STEPS(STEPS), .SUB_WAIT(SUB_W), .AZ_WAIT(AZ_W)) dut (.*);

    wire [7:0] swv = {sw_in_o, sw_g_o, sw_x_fb_o, sw_x_st_o, sw_x_rd_o, sw_y_fb_o, sw_y_st_o, sw_y_rd_o};
    wire [1:0] refv = {ref_a1_o, ref_a2_o};
    wire [1:0] azv  = {az_amp_o, az_ref_o};

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            failures++;
            $display("FAIL watchdog: run hung (act cycles %0d, exp < 150000)", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s at cycle %0d: act=%0d exp=%0d", req, cyc, act, exp);
        end
    endtask

    // bit order: in g xfb xst xrd yfb yst yrd
    function automatic logic [7:0] exp_decide(input int k);
        logic [7:0] v = 8'b0100_0000;
        if (k == 0) v[7] = 1'b1;
        else if (k % 2 == 1) v[3] = 1'b1;
        else v[0] = 1'b1;
        return v;
    endfunction

    function automatic logic [7:0] exp_sub(input int k);
        logic [7:0] v = 8'b0;
        if (k == 0) v[7] = 1'b1;
        else if (k % 2 == 1) v[3] = 1'b1;
        else v[0] = 1'b1;
        if (k % 2 == 1) begin v[2] = 1'b1; v[1] = 1'b1; end
        else begin v[5] = 1'b1; v[4] = 1'b1; end
        return v;
    endfunction

    function automatic longint exp_result(input bit c0, input logic [24:0] codes);
        longint r = 0;
        for (int k = 0; k < 5; k++) begin
            bit s = c0 ^ k[0];
            longint cv = longint'(codes[k*5 +: 5]);
            r = r * 16 + (s ? cv : -cv);
        end
        return r;
    endfunction

    // Entered just after a negedge with the block idle.
    task automatic run_conv(input bit c0, input logic [24:0] codes, input bit poke);
        longint expv = exp_result(c0, codes);
        cmp_i = c0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(swv == 8'h00 && busy_o, "R7 break before sense", swv, 0);
        @(negedge clk);
        chk(swv == 8'b1100_0000, "R2 sense input+G", swv, 8'b1100_0000);
        @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            bit s = c0 ^ k[0];
            int d = $urandom_range(0, 3);
            chk(dec_start_o == 1'b1, "R3 decision request", dec_start_o, 1);
            chk(swv == exp_decide(k), "R5 decision switches", swv, exp_decide(k));
            chk(refv == (s ? 2'b10 : 2'b01), "R6 reference polarity", refv, s ? 2 : 1);
            for (int j = 0; j < d; j++) begin
                if (poke && k == 2 && j == 0) start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                chk(dec_start_o == 1'b0 && swv == exp_decide(k), "R3 decision held", swv, exp_decide(k));
            end
            if (poke && k == 2 && d == 0) start_i = 1'b1;
            dec_done_i = 1'b1;
            dec_code_i = codes[k*5 +: 5];
            @(negedge clk);
            dec_done_i = 1'b0;
            start_i = 1'b0;
            chk(swv == 8'h00, "R7 break before subtraction", swv, 0);
            for (int j = 0; j < SUB_W; j++) begin
                @(negedge clk);
                chk(swv == exp_sub(k), "R4 subtraction switches", swv, exp_sub(k));
                chk(refv == (s ? 2'b10 : 2'b01), "R6 reference held", refv, s ? 2 : 1);
            end
            @(negedge clk);
            chk(swv == 8'h00, "R7 break after subtraction", swv, 0);
            if (k < 4) @(negedge clk);
        end
        for (int j = 0; j < AZ_W; j++) begin
            @(negedge clk);
            chk(swv == 8'b0010_0000 && azv == 2'b10 && refv == 2'b00, "R8 amplifier autozero",
                {azv, refv, swv}, {2'b10, 2'b00, 8'b0010_0000});
        end
        @(negedge clk);
        chk(swv == 8'h00 && azv == 2'b00, "R7 break before reference autozero", swv, 0);
        for (int j = 0; j < AZ_W; j++) begin
            @(negedge clk);
            chk(refv == 2'b10 && azv == 2'b00 && swv == 8'h00, "R9 reference autozero phase 1",
                {azv, refv}, 4'b0010);
        end
        for (int j = 0; j < AZ_W; j++) begin
            @(negedge clk);
            chk(refv == 2'b00 && azv == 2'b01 && swv == 8'h00, "R9 reference autozero phase 2",
                {azv, refv}, 4'b0100);
        end
        @(negedge clk);
        chk(done_o == 1'b1, "R10 done strobe", done_o, 1);
        chk(longint'(result_o) == expv, "R10 result value", longint'(result_o), expv);
        @(negedge clk);
        chk(done_o == 1'b0, "R10 done one cycle", done_o, 0);
        chk(longint'(result_o) == expv, "R10 result held", longint'(result_o), expv);
        chk(!busy_o && swv == 8'h00 && refv == 2'b00 && azv == 2'b00, "R1 idle after conversion", swv, 0);
        if (poke) begin
            repeat (3) @(negedge clk);
            chk(!busy_o && !dec_start_o, "R11 start while busy ignored", busy_o, 0);
        end
    endtask

    initial begin
        void'($urandom(32'h00C5_0A11));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy_o && !done_o && !dec_start_o && swv == 8'h00 && refv == 2'b00 && azv == 2'b00,
            "R1 reset state", {busy_o, done_o, dec_start_o, swv}, 0);
        // R10 directed extremes
        run_conv(1'b1, {5{5'd31}}, 1'b0);
        run_conv(1'b0, {5{5'd31}}, 1'b0);
        run_conv(1'b1, 25'd0, 1'b0);
        // R11 start arriving mid-conversion
        run_conv(1'b0, {5'd3, 5'd17, 5'd9, 5'd30, 5'd1}, 1'b1);
        for (int n = 0; n < 24; n++) begin
            logic [24:0] cv = 25'($urandom);
            bit c0 = 1'($urandom);
            bit pk = (n % 6 == 5);
            run_conv(c0, cv, pk);
        end
        summary();
        $finish;
    end
endmodule